// File: doc/BRIEF.md
# Microcode Control-Flow Sequencer

This block is the program-counter and control-flow unit of a small command-processing microcontroller. It holds the program counter, presents it as the instruction-memory address, and looks at the 6-bit header in the top bits of the returned 32-bit word. Headers from 0x30 upward are control-flow instructions. These are conditional relative branches that compare a register value against an immediate or test one of its bits, absolute calls, returns through a small hardware return stack, and a wait instruction that halts the sequencer until an external producer moves its write pointer. Every header below 0x30 belongs to the arithmetic and memory instructions, and the sequencer simply steps past them.

The instruction memory and the register file are read combinationally in the same cycle. The sequencer drives the memory address and the register index, takes back the word and the register value, and retires one instruction per cycle unless it is waiting. A sticky flag reports return-stack misuse.

Top module: `useq_top`

## Requirements
- R1: After reset the instruction address is 0, the return stack is empty, the latched read-pointer copy is 0, and both stall and the stack error flag are low.
- R2: A word whose header (bits [31:26]) is below 0x30, or is an unassigned value of 0x37 or above, advances the address by one.
- R3: Header 0x30 branches when the register differs from the zero-extended 5-bit immediate in bits [20:16]. Header 0x31 branches when they are equal, with all register bits taking part in the comparison.
- R4: Header 0x32 branches when the register bit selected by bits [20:16] is 0. Header 0x33 branches when that bit is 1.
- R5: A taken branch loads the address plus the sign-extended 16-bit offset in bits [15:0], wrapping modulo the address width. A branch that is not taken advances by one.
- R6: Header 0x35 pushes the address plus one and jumps to the absolute target in bits [25:0], truncated to the address width.
- R7: Header 0x34 pops the most recently pushed address and jumps to it, in last-in first-out order.
- R8: A call with the stack holding STACK_DEPTH entries, or a return with it empty, leaves the stack unchanged, advances the address by one and sets the error flag.
- R9: Header 0x36 with the write pointer equal to the latched copy holds the address and drives stall high for every such cycle. Stall is low on all other instructions.
- R10: Header 0x36 with the write pointer different from the latched copy drives stall low in that cycle, advances the address by one and latches the new pointer, so the next wait holds until the pointer moves again.
- R11: The error flag stays set until reset.
- R12: The register index output equals bits [25:21] of the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| imemAddr | output | PC_W | Program counter, used as the instruction-memory address |
| imemData | input | 32 | Instruction word at imemAddr |
| regRdAddr | output | 5 | Register index taken from the current word |
| regRdData | input | REG_W | Value of the indexed register |
| wrPtr | input | PTR_W | Producer write pointer |
| stall | output | 1 | High while a wait instruction is holding |
| stackErr | output | 1 | Sticky return-stack overflow/underflow flag |

## Verification
The bench builds the block with an 8-bit program counter, a 4-entry stack and a 4-bit write pointer. The narrow address makes offset wrap-around and the truncation of wide call targets reachable within a few instructions. The 4-entry stack lets a chain of five nested calls reach overflow, and the unwinding afterwards shows that the stored return addresses survived it. Register values with high bits set next to a matching low field show that the immediate comparison uses the whole register.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam logic [5:0] HDR_FIRST_CF = 6'h30;
  localparam logic [5:0] HDR_BR_NE_IMM = 6'h30;
  localparam logic [5:0] HDR_BR_EQ_IMM = 6'h31;
  localparam logic [5:0] HDR_BR_BIT_CLR = 6'h32;
  localparam logic [5:0] HDR_BR_BIT_SET = 6'h33;
  localparam logic [5:0] HDR_RETURN = 6'h34;
  localparam logic [5:0] HDR_CALL = 6'h35;
  localparam logic [5:0] HDR_WAIT_IN = 6'h36;

  // Strobes from control to datapath; none set means "advance by one".
  typedef struct packed {
    logic hold;     // keep the program counter
    logic jumpRel;  // pc + sign-extended offset
    logic call;     // push pc+1, load absolute target
    logic ret;      // pop and load popped address
    logic errSet;   // flag stack misuse
    logic ptrLoad;  // latch write pointer into read copy
  } seqStrobe_t;

endpackage

// File: rtl/useq_control.sv
module useq_control
  import useq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic [15:0]      instrHi,
  input  logic [REG_W-1:0] regData,
  input  logic             stackFull,
  input  logic             stackEmpty,
  input  logic             ptrDiffers,
  output seqStrobe_t       strobe,
  output logic             stall,
  output logic [4:0]       regAddr
);

  logic [5:0] hdr;
  logic [4:0] immOrBit;
  logic       immEqual;
  logic       bitValue;

  assign hdr      = instrHi[15:10];
  assign regAddr  = instrHi[9:5];
  assign immOrBit = instrHi[4:0];

  assign immEqual = (regData == REG_W'(immOrBit));
  assign bitValue = |((regData >> immOrBit) & REG_W'(1));

  always_comb begin
    strobe = '0;
    stall  = 1'b0;
    case (hdr)
      HDR_BR_NE_IMM:  strobe.jumpRel = !immEqual;
      HDR_BR_EQ_IMM:  strobe.jumpRel = immEqual;
      HDR_BR_BIT_CLR: strobe.jumpRel = !bitValue;
      HDR_BR_BIT_SET: strobe.jumpRel = bitValue;
      HDR_RETURN: begin
        if (stackEmpty) strobe.errSet = 1'b1;
        else            strobe.ret    = 1'b1;
      end
      HDR_CALL: begin
        if (stackFull) strobe.errSet = 1'b1;
        else           strobe.call   = 1'b1;
      end
      HDR_WAIT_IN: begin
        if (ptrDiffers) begin
          strobe.ptrLoad = 1'b1;
        end else begin
          strobe.hold = 1'b1;
          stall       = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/useq_datapath.sv
module useq_datapath
  import useq_pkg::*;
#(
  parameter int PC_W        = 16,
  parameter int STACK_DEPTH = 4,
  parameter int PTR_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [15:0]      relOff,
  input  logic [PC_W-1:0]  callTgt,
  input  logic [PTR_W-1:0] wrPtr,
  output logic [PC_W-1:0]  pc,
  output logic             stackFull,
  output logic             stackEmpty,
  output logic             ptrDiffers,
  output logic             stackErr
);

  localparam int SP_W  = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W = $clog2(STACK_DEPTH);

  logic [SP_W-1:0]                    sp;
  logic [IDX_W-1:0]                   topIdx;
  logic [STACK_DEPTH-1:0][PC_W-1:0]   stkFlat;
  logic [PTR_W-1:0]                   rdCopy;
  logic [PC_W-1:0]                    pcInc;
  logic [PC_W-1:0]                    pcNext;

  assign pcInc      = pc + PC_W'(1);
  assign topIdx     = IDX_W'(sp - SP_W'(1));
  assign stackFull  = (sp == SP_W'(STACK_DEPTH));
  assign stackEmpty = (sp == '0);
  assign ptrDiffers = (wrPtr != rdCopy);

  always_comb begin
    if (strobe.hold)         pcNext = pc;
    else if (strobe.jumpRel) pcNext = pc + PC_W'($signed(relOff));
    else if (strobe.call)    pcNext = callTgt;
    else if (strobe.ret)     pcNext = stkFlat[topIdx];
    else                     pcNext = pcInc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc       <= '0;
      sp       <= '0;
      rdCopy   <= '0;
      stackErr <= 1'b0;
    end else begin
      pc <= pcNext;
      if (strobe.call)    sp <= sp + SP_W'(1);
      else if (strobe.ret) sp <= sp - SP_W'(1);
      if (strobe.ptrLoad) rdCopy <= wrPtr;
      if (strobe.errSet)  stackErr <= 1'b1;
    end
  end

  // One register per return-stack slot; a slot is written when it is next free.
  for (genvar i = 0; i < STACK_DEPTH; i++) begin : g_slot
    logic [PC_W-1:0] entry;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   entry <= '0;
      else if (strobe.call && sp == SP_W'(i))      entry <= pcInc;
    end
    assign stkFlat[i] = entry;
  end

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int PC_W        = 16,  // at most 26
  parameter int STACK_DEPTH = 4,   // at least 2
  parameter int PTR_W       = 16,
  parameter int REG_W       = 32
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [PC_W-1:0]  imemAddr,
  input  logic [31:0]      imemData,
  output logic [4:0]       regRdAddr,
  input  logic [REG_W-1:0] regRdData,
  input  logic [PTR_W-1:0] wrPtr,
  output logic             stall,
  output logic             stackErr
);

  seqStrobe_t strobe;
  logic       stackFull;
  logic       stackEmpty;
  logic       ptrDiffers;

  useq_control #(.REG_W(REG_W)) u_ctrl (
    .instrHi    (imemData[31:16]),
    .regData    (regRdData),
    .stackFull  (stackFull),
    .stackEmpty (stackEmpty),
    .ptrDiffers (ptrDiffers),
    .strobe     (strobe),
    .stall      (stall),
    .regAddr    (regRdAddr)
  );

  useq_datapath #(
    .PC_W(PC_W), .STACK_DEPTH(STACK_DEPTH), .PTR_W(PTR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .relOff     (imemData[15:0]),
    .callTgt    (imemData[PC_W-1:0]),
    .wrPtr      (wrPtr),
    .pc         (imemAddr),
    .stackFull  (stackFull),
    .stackEmpty (stackEmpty),
    .ptrDiffers (ptrDiffers),
    .stackErr   (stackErr)
  );

endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
  parameter int PC_W  = 16,
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [PC_W-1:0]  imemAddr,
  input logic [31:0]      imemData,
  input logic [4:0]       regRdAddr,
  input logic [REG_W-1:0] regRdData,
  input logic             stall,
  input logic             stackErr
);

  logic [5:0]      hdr;
  logic [PC_W-1:0] seqNext;
  logic [PC_W-1:0] brTarget;
  logic            immMatch;

  assign hdr      = imemData[31:26];
  assign seqNext  = imemAddr + PC_W'(1);
  assign brTarget = imemAddr + PC_W'($signed(imemData[15:0]));
  assign immMatch = (regRdData == REG_W'(imemData[20:16]));

  a_r2_plain_advance: assert property (@(posedge clk) disable iff (!rstN)
    hdr < 6'h30 |=> imemAddr == $past(seqNext));

  a_r3_eq_imm_taken: assert property (@(posedge clk) disable iff (!rstN)
    (hdr == 6'h31 && immMatch) |=> imemAddr == $past(brTarget));

  a_r6_call_target: assert property (@(posedge clk) disable iff (!rstN)
    hdr == 6'h35 |=> (imemAddr == $past(imemData[PC_W-1:0]))
                     || (stackErr && imemAddr == $past(seqNext)));

  a_r9_hold_on_wait: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> imemAddr == $past(imemAddr));

  a_r9_stall_only_wait: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> hdr == 6'h36);

  a_r10_resume: assert property (@(posedge clk) disable iff (!rstN)
    (hdr == 6'h36 && !stall) |=> imemAddr == $past(seqNext));

  a_r11_sticky_err: assert property (@(posedge clk) disable iff (!rstN)
    stackErr |=> stackErr);

  a_r12_reg_index: assert property (@(posedge clk) disable iff (!rstN)
    regRdAddr == imemData[25:21]);

endmodule

bind useq_top useq_checker #(.PC_W(PC_W), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .imemAddr  (imemAddr),
  .imemData  (imemData),
  .regRdAddr (regRdAddr),
  .regRdData (regRdData),
  .stall     (stall),
  .stackErr  (stackErr)
);

// File: tb/useq_top_test.sv
`timescale 1ns/1ps
module useq_top_test;

  localparam int PC_W  = 8;
  localparam int DEPTH = 4;
  localparam int PTR_W = 4;
  localparam int REG_W = 32;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [PC_W-1:0]  imemAddr;
  logic [31:0]      imemData;
  logic [4:0]       regRdAddr;
  logic [REG_W-1:0] regRdData;
  logic [PTR_W-1:0] wrPtr = '0;
  logic             stall;
  logic             stackErr;

  logic [31:0]      imem [256];
  logic [REG_W-1:0] regs [32];

  int  nChecks = 0;
  int  nBad = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  assign imemData  = imem[imemAddr];
  assign regRdData = regs[regRdAddr];

  useq_top #(.PC_W(PC_W), .STACK_DEPTH(DEPTH), .PTR_W(PTR_W), .REG_W(REG_W)) uut (
    .clk(clk), .rstN(rstN), .imemAddr(imemAddr), .imemData(imemData),
    .regRdAddr(regRdAddr), .regRdData(regRdData), .wrPtr(wrPtr),
    .stall(stall), .stackErr(stackErr)
  );

  function automatic logic [31:0] brW(input logic [5:0] h, input logic [4:0] r,
                                      input logic [4:0] f, input int off);
    return {h, r, f, 16'(off)};
  endfunction

  function automatic logic [31:0] callW(input logic [25:0] tgt);
    return {6'h35, tgt};
  endfunction

  localparam logic [31:0] RET_W  = {6'h34, 26'd0};
  localparam logic [31:0] WAIT_W = {6'h36, 26'd0};

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic holdReset();
    @(negedge clk);
    rstN = 1'b0;
    wrPtr = '0;
    for (int i = 0; i < 256; i++) imem[i] = 32'd0;
    for (int i = 0; i < 32; i++) regs[i] = '0;
    @(negedge clk);
  endtask

  task automatic release_();
    rstN = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    holdReset();
    release_();
    #1;
    chk("R1", "addr", 32'(imemAddr), 0);
    chk("R1", "stall", 32'(stall), 0);
    chk("R1", "err", 32'(stackErr), 0);
  endtask

  task automatic testSequential();
    holdReset();
    imem[0] = {6'h2f, 26'h3ff_ffff};
    imem[1] = {6'h37, 26'h000_0005};
    imem[2] = {6'h22, 26'h123_4567};
    release_();
    step(1); chk("R2", "hdr 0x2f", 32'(imemAddr), 1);
    chk("R9", "no stall on plain word", 32'(stall), 0);
    step(1); chk("R2", "hdr 0x37", 32'(imemAddr), 2);
    step(1); chk("R2", "hdr 0x22", 32'(imemAddr), 3);
  endtask

  task automatic testImmBranch();
    holdReset();
    regs[5] = 32'd7;
    regs[6] = 32'h107;
    imem[0]  = brW(6'h31, 5'd5, 5'd7, 10);
    imem[10] = brW(6'h30, 5'd5, 5'd7, 4);
    imem[11] = brW(6'h30, 5'd5, 5'd3, -5);
    imem[6]  = brW(6'h31, 5'd6, 5'd7, 2);
    release_();
    #1; chk("R12", "reg index", 32'(regRdAddr), 5);
    step(1); chk("R3", "eq imm taken", 32'(imemAddr), 10);
    step(1); chk("R3", "ne imm not taken", 32'(imemAddr), 11);
    step(1); chk("R5", "ne imm taken backward", 32'(imemAddr), 6);
    #1; chk("R12", "reg index 6", 32'(regRdAddr), 6);
    step(1); chk("R3", "high reg bits block equality", 32'(imemAddr), 7);
  endtask

  task automatic testBitBranch();
    holdReset();
    regs[9] = 32'h8000_0001;
    imem[0]  = brW(6'h33, 5'd9, 5'd31, 20);
    imem[20] = brW(6'h32, 5'd9, 5'd0, 5);
    imem[21] = brW(6'h32, 5'd9, 5'd4, -21);
    release_();
    step(1); chk("R4", "bit set taken", 32'(imemAddr), 20);
    step(1); chk("R4", "bit clr not taken", 32'(imemAddr), 21);
    step(1); chk("R4", "bit clr taken", 32'(imemAddr), 0);
  endtask

  task automatic testWrap();
    holdReset();
    imem[0]   = brW(6'h31, 5'd0, 5'd0, -2);
    imem[254] = brW(6'h30, 5'd0, 5'd1, 5);
    release_();
    step(1); chk("R5", "wrap below zero", 32'(imemAddr), 254);
    step(1); chk("R5", "wrap past top", 32'(imemAddr), 3);
  endtask

  task automatic testCallRet();
    holdReset();
    imem[0]  = callW(26'h3ff_ff28);
    imem[40] = callW(26'd80);
    imem[80] = RET_W;
    imem[41] = RET_W;
    release_();
    step(1); chk("R6", "truncated call target", 32'(imemAddr), 40);
    step(1); chk("R6", "nested call", 32'(imemAddr), 80);
    step(1); chk("R7", "inner return", 32'(imemAddr), 41);
    step(1); chk("R7", "outer return", 32'(imemAddr), 1);
    chk("R8", "no error on balanced use", 32'(stackErr), 0);
  endtask

  task automatic testOverflow();
    holdReset();
    imem[0]  = callW(26'd10);
    imem[10] = callW(26'd20);
    imem[20] = callW(26'd30);
    imem[30] = callW(26'd40);
    imem[40] = callW(26'd50);
    imem[41] = RET_W;
    imem[31] = RET_W;
    imem[21] = RET_W;
    imem[11] = RET_W;
    imem[1]  = RET_W;
    release_();
    step(4); chk("R6", "four calls deep", 32'(imemAddr), 40);
    chk("R8", "full stack no error yet", 32'(stackErr), 0);
    step(1); chk("R8", "overflow advances", 32'(imemAddr), 41);
    chk("R8", "overflow error", 32'(stackErr), 1);
    step(1); chk("R8", "stack intact 1", 32'(imemAddr), 31);
    step(1); chk("R8", "stack intact 2", 32'(imemAddr), 21);
    step(1); chk("R8", "stack intact 3", 32'(imemAddr), 11);
    step(1); chk("R7", "last return", 32'(imemAddr), 1);
    step(1); chk("R8", "underflow advances", 32'(imemAddr), 2);
    step(3); chk("R11", "error sticky", 32'(stackErr), 1);
    holdReset();
    release_();
    #1; chk("R11", "reset clears error", 32'(stackErr), 0);
  endtask

  task automatic testUnderflow();
    holdReset();
    imem[0] = RET_W;
    release_();
    step(1); chk("R8", "underflow addr", 32'(imemAddr), 1);
    chk("R8", "underflow error", 32'(stackErr), 1);
  endtask

  task automatic testWait();
    holdReset();
    imem[1] = WAIT_W;
    imem[2] = WAIT_W;
    release_();
    step(1); chk("R9", "at wait", 32'(imemAddr), 1);
    chk("R9", "stall while equal", 32'(stall), 1);
    step(3); chk("R9", "held", 32'(imemAddr), 1);
    chk("R9", "still stalled", 32'(stall), 1);
    wrPtr = 4'd3;
    #1; chk("R10", "stall drops on move", 32'(stall), 0);
    step(1); chk("R10", "resumed", 32'(imemAddr), 2);
    chk("R10", "new copy latched", 32'(stall), 1);
    step(2); chk("R10", "second wait holds", 32'(imemAddr), 2);
    wrPtr = 4'd4;
    step(1); chk("R10", "second resume", 32'(imemAddr), 3);
    chk("R9", "no stall after wait", 32'(stall), 0);
  endtask

  initial begin
    testReset();
    testSequential();
    testImmBranch();
    testBitBranch();
    testWrap();
    testCallRet();
    testOverflow();
    testUnderflow();
    testWait();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule